// File: doc/BRIEF.md
# Inertial Burst Frame Aligner and CRC Checker

This block sits behind the serial receiver of an inertial sensor interface. During a burst read the receiver delivers a fixed window of twenty 16-bit words, one per `word_valid` cycle. The head of that window holds one or two copies of a sync marker (0xA5A5), and how many copies appear depends on the serial clock rate. The block stores the window and finds where the payload starts by looking for the point where the sync marker stops. It then recomputes the frame's CRC32 one byte per clock and compares it with the 32-bit check value carried at the tail of the payload.

On a match it presents one validated record: the status word, the temperature word, the three gyro and three accelerometer 32-bit samples rebuilt from their split halves, and the frame counter unchanged. This comes with a one-cycle `rec_valid` pulse. A frame with no sync transition, or with a wrong CRC, produces a one-cycle `err_valid` pulse and a code that says which fault occurred, and the record outputs keep their previous contents. A `frame_start` pulse aborts whatever is in progress and opens a new capture window.

Top module: `imu_burst_frame_check`

## Requirements
- R1: Exactly 20 words are stored per frame, in arrival order, on cycles with `word_valid` high. After the 20th word, further words are ignored until the next `frame_start`, and the result is unaffected by them.
- R2: The payload offset is i+1, where i is the lowest index in 0..3 for which word[i] equals 0xA5A5 and word[i+1] does not.
- R3: If no index in 0..3 meets the rule in R2, `err_valid` pulses with `result_code` = 1 (sync error) in the first cycle after the clock edge that accepts the 20th word, and no record is produced.
- R4: The computed CRC is reflected CRC32 (polynomial 0xEDB88320, initial value all ones, final XOR all ones) over the 15 payload words p..p+14. Each word is fed low byte first, then high byte.
- R5: The received CRC is {word[p+16], word[p+15]}. A payload index beyond word 19 reads as 0x0000.
- R6: A CRC mismatch gives an `err_valid` pulse with `result_code` = 2 (CRC error), and the record outputs do not change.
- R7: A CRC match gives a `rec_valid` pulse with `result_code` = 0. The pulse appears 32 cycles after the clock edge that accepts the 20th word.
- R8: The record is laid out as follows: status = word[p]; temperature = word[p+1]; gyro X, Y, Z and then accel X, Y, Z are {word[p+2k+3], word[p+2k+2]} for k = 0..5 (upper half on the left); counter = word[p+14], unchanged.
- R9: `rec_valid` and `err_valid` each last one cycle, are never high together, and at most one of them pulses per frame.
- R10: `frame_start` clears capture and processing. A word presented in the same cycle becomes word 0 of the new frame, and the result of an aborted frame is never reported.
- R11: The record outputs change only together with a `rec_valid` pulse, and hold through errors and through `frame_start`.
- R12: After reset the strobes are low, `result_code` is 0, and every record field is zero. The block then accepts a frame without needing a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Opens a new capture window and aborts the current frame |
| word_valid | input | 1 | `word_data` carries a captured word this cycle |
| word_data | input | 16 | Captured 16-bit word |
| rec_valid | output | 1 | One-cycle pulse: the record outputs hold a validated frame |
| err_valid | output | 1 | One-cycle pulse: the frame was rejected |
| result_code | output | 2 | 0 ok, 1 sync error, 2 CRC error; holds its last value |
| rec_status | output | 16 | Status word |
| rec_temp | output | 16 | Temperature word |
| rec_gyro_x | output | 32 | Gyro X sample |
| rec_gyro_y | output | 32 | Gyro Y sample |
| rec_gyro_z | output | 32 | Gyro Z sample |
| rec_accel_x | output | 32 | Accelerometer X sample |
| rec_accel_y | output | 32 | Accelerometer Y sample |
| rec_accel_z | output | 32 | Accelerometer Z sample |
| rec_counter | output | 16 | Frame counter word, passed through |

## Verification
Results come on two fixed schedules, both counted from the clock edge that accepts the 20th word. A sync error is reported one cycle after that edge. A CRC verdict, whether match or mismatch, is reported 32 cycles after it: 30 byte steps plus one compare cycle and one register stage. For each frame the bench counts sampled edges from that accepting edge and compares the count with the value it expects for the verdict its own model gives. It then samples for six more cycles to show that no second strobe follows. All sampling happens one time unit after a rising edge, and all inputs change on falling edges.

// File: rtl/imu_burst_pkg.sv
package imu_burst_pkg;

  localparam int unsigned WORD_W     = 16;
  localparam int unsigned CRC_W      = 32;
  localparam int unsigned AXIS_COUNT = 6;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED      = 32'hFFFFFFFF;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_SYNC_ERR = 2'd1,
    RES_CRC_ERR  = 2'd2
  } result_e;

  typedef enum logic [1:0] {
    ST_CAPTURE = 2'd0,
    ST_CRC     = 2'd1,
    ST_FINISH  = 2'd2,
    ST_DONE    = 2'd3
  } phase_e;

  // One byte of reflected CRC32, shift-right form.
  function automatic logic [CRC_W-1:0] crc32_refl_byte(input logic [CRC_W-1:0] crc_in,
                                                       input logic [7:0] data);
    logic [CRC_W-1:0] c;
    c = crc_in ^ {24'd0, data};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/imu_burst_capture.sv
module imu_burst_capture #(
  parameter int unsigned DEPTH = 20,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        wr_en,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] words,
  output logic [CNT_W-1:0]            fill_cnt,
  output logic                        full
);

  logic [WIDTH-1:0] slot_q [DEPTH];

  assign full = (fill_cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
    end else if (clear) begin
      fill_cnt <= wr_en ? CNT_W'(1) : '0;
    end else if (wr_en && !full) begin
      fill_cnt <= fill_cnt + CNT_W'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel;
    assign sel = clear ? (i == 0) : (!full && (fill_cnt == CNT_W'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[i] <= '0;
      end else if (wr_en && sel) begin
        slot_q[i] <= wr_data;
      end
    end
    assign words[i] = slot_q[i];
  end

endmodule

// File: rtl/imu_burst_align.sv
module imu_burst_align #(
  parameter int unsigned SCAN_POS  = 4,
  parameter int unsigned WIDTH     = 16,
  parameter logic [WIDTH-1:0] SYNC_WORD = 16'hA5A5,
  localparam int unsigned OFF_W = $clog2(SCAN_POS + 1)
) (
  input  logic [SCAN_POS:0][WIDTH-1:0] head,
  output logic                         found,
  output logic [OFF_W-1:0]             pay_off
);

  logic [SCAN_POS-1:0] edge_hit;

  for (genvar i = 0; i < SCAN_POS; i++) begin : g_scan
    assign edge_hit[i] = (head[i] == SYNC_WORD) && (head[i+1] != SYNC_WORD);
  end

  // Lowest index wins: walk from the top so the last write is the lowest hit.
  always_comb begin
    found   = 1'b0;
    pay_off = '0;
    for (int i = SCAN_POS - 1; i >= 0; i--) begin
      if (edge_hit[i]) begin
        found   = 1'b1;
        pay_off = OFF_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/imu_burst_crc.sv
module imu_burst_crc
  import imu_burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic [7:0]       data_byte,
  output logic [CRC_W-1:0] crc_final
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
    end else if (init) begin
      crc_q <= CRC_SEED;
    end else if (step) begin
      crc_q <= crc32_refl_byte(crc_q, data_byte);
    end
  end

  assign crc_final = ~crc_q;

endmodule

// File: rtl/imu_burst_frame_check.sv
module imu_burst_frame_check
  import imu_burst_pkg::*;
#(
  parameter int unsigned FRAME_WORDS = 20,
  parameter int unsigned SCAN_POS    = 4,
  parameter logic [WORD_W-1:0] SYNC_WORD = 16'hA5A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              rec_valid,
  output logic              err_valid,
  output logic [1:0]        result_code,
  output logic [WORD_W-1:0] rec_status,
  output logic [WORD_W-1:0] rec_temp,
  output logic [31:0]       rec_gyro_x,
  output logic [31:0]       rec_gyro_y,
  output logic [31:0]       rec_gyro_z,
  output logic [31:0]       rec_accel_x,
  output logic [31:0]       rec_accel_y,
  output logic [31:0]       rec_accel_z,
  output logic [WORD_W-1:0] rec_counter
);

  // Payload layout relative to the payload offset.
  localparam int unsigned PL_STATUS = 0;
  localparam int unsigned PL_TEMP   = 1;
  localparam int unsigned PL_AXIS   = 2;
  localparam int unsigned PL_COUNT  = PL_AXIS + 2 * AXIS_COUNT;
  localparam int unsigned CRC_WORDS = PL_COUNT + 1;
  localparam int unsigned PL_CRC_LO = CRC_WORDS;
  localparam int unsigned PL_CRC_HI = CRC_WORDS + 1;
  localparam int unsigned CRC_BYTES = CRC_WORDS * 2;
  localparam int unsigned CNT_W     = $clog2(FRAME_WORDS + 1);
  localparam int unsigned IDX_W     = $clog2(FRAME_WORDS);
  localparam int unsigned OFF_W     = $clog2(SCAN_POS + 1);
  localparam int unsigned BYTE_W    = $clog2(CRC_BYTES + 1);

  function automatic logic [WORD_W-1:0] pick_word(
      input logic [FRAME_WORDS-1:0][WORD_W-1:0] w, input logic [31:0] idx);
    if (idx < FRAME_WORDS) return w[idx[IDX_W-1:0]];
    return '0;
  endfunction

  function automatic logic [31:0] pidx(input logic [OFF_W-1:0] off, input int unsigned rel);
    return 32'(off) + 32'(rel);
  endfunction

  phase_e                            state_q;
  logic [FRAME_WORDS-1:0][WORD_W-1:0] cap_words;
  logic [CNT_W-1:0]                  fill_cnt;
  logic                              cap_full;
  logic                              cap_wr;
  logic                              align_found;
  logic [OFF_W-1:0]                  align_off;
  logic [OFF_W-1:0]                  pay_off_q;
  logic [BYTE_W-1:0]                 byte_idx_q;
  logic [WORD_W-1:0]                 crc_word;
  logic [7:0]                        crc_byte;
  logic [CRC_W-1:0]                  crc_calc;
  logic [CRC_W-1:0]                  crc_rx;
  logic                              crc_init;

  // Named internal events (observed by the bound checker).
  logic align_eval;
  logic crc_step;
  logic crc_last;
  logic crc_match_evt;
  logic crc_miss_evt;

  assign cap_wr = word_valid && (frame_start || (state_q == ST_CAPTURE));

  imu_burst_capture #(
    .DEPTH (FRAME_WORDS),
    .WIDTH (WORD_W)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (frame_start),
    .wr_en    (cap_wr),
    .wr_data  (word_data),
    .words    (cap_words),
    .fill_cnt (fill_cnt),
    .full     (cap_full)
  );

  imu_burst_align #(
    .SCAN_POS  (SCAN_POS),
    .WIDTH     (WORD_W),
    .SYNC_WORD (SYNC_WORD)
  ) u_align (
    .head    (cap_words[SCAN_POS:0]),
    .found   (align_found),
    .pay_off (align_off)
  );

  assign align_eval = (state_q == ST_CAPTURE) && cap_full && !frame_start;
  assign crc_step   = (state_q == ST_CRC) && !frame_start;
  assign crc_last   = crc_step && (byte_idx_q == BYTE_W'(CRC_BYTES - 1));
  assign crc_init   = frame_start || (align_eval && align_found);

  assign crc_word = pick_word(cap_words, pidx(pay_off_q, 32'(byte_idx_q >> 1)));
  assign crc_byte = byte_idx_q[0] ? crc_word[15:8] : crc_word[7:0];

  imu_burst_crc u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (crc_init),
    .step      (crc_step),
    .data_byte (crc_byte),
    .crc_final (crc_calc)
  );

  assign crc_rx = {pick_word(cap_words, pidx(pay_off_q, PL_CRC_HI)),
                   pick_word(cap_words, pidx(pay_off_q, PL_CRC_LO))};

  assign crc_match_evt = (state_q == ST_FINISH) && !frame_start && (crc_calc == crc_rx);
  assign crc_miss_evt  = (state_q == ST_FINISH) && !frame_start && (crc_calc != crc_rx);

  // Control sequence.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_CAPTURE;
      pay_off_q   <= '0;
      byte_idx_q  <= '0;
      rec_valid   <= 1'b0;
      err_valid   <= 1'b0;
      result_code <= RES_OK;
    end else begin
      rec_valid <= 1'b0;
      err_valid <= 1'b0;
      if (frame_start) begin
        state_q    <= ST_CAPTURE;
        byte_idx_q <= '0;
      end else begin
        unique case (state_q)
          ST_CAPTURE: begin
            if (align_eval) begin
              if (align_found) begin
                pay_off_q  <= align_off;
                byte_idx_q <= '0;
                state_q    <= ST_CRC;
              end else begin
                err_valid   <= 1'b1;
                result_code <= RES_SYNC_ERR;
                state_q     <= ST_DONE;
              end
            end
          end
          ST_CRC: begin
            byte_idx_q <= byte_idx_q + BYTE_W'(1);
            if (crc_last) state_q <= ST_FINISH;
          end
          ST_FINISH: begin
            if (crc_match_evt) begin
              rec_valid   <= 1'b1;
              result_code <= RES_OK;
            end else begin
              err_valid   <= 1'b1;
              result_code <= RES_CRC_ERR;
            end
            state_q <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  // Record assembly: upper half on the left of each 32-bit sample.
  logic [AXIS_COUNT-1:0][31:0] axis_asm;
  logic [AXIS_COUNT-1:0][31:0] axis_q;
  logic [WORD_W-1:0]           status_q, temp_q, count_q;

  for (genvar a = 0; a < AXIS_COUNT; a++) begin : g_axis
    assign axis_asm[a] = {pick_word(cap_words, pidx(pay_off_q, PL_AXIS + 2 * a + 1)),
                          pick_word(cap_words, pidx(pay_off_q, PL_AXIS + 2 * a))};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      axis_q   <= '0;
      status_q <= '0;
      temp_q   <= '0;
      count_q  <= '0;
    end else if (crc_match_evt) begin
      axis_q   <= axis_asm;
      status_q <= pick_word(cap_words, pidx(pay_off_q, PL_STATUS));
      temp_q   <= pick_word(cap_words, pidx(pay_off_q, PL_TEMP));
      count_q  <= pick_word(cap_words, pidx(pay_off_q, PL_COUNT));
    end
  end

  assign rec_status  = status_q;
  assign rec_temp    = temp_q;
  assign rec_counter = count_q;
  assign rec_gyro_x  = axis_q[0];
  assign rec_gyro_y  = axis_q[1];
  assign rec_gyro_z  = axis_q[2];
  assign rec_accel_x = axis_q[3];
  assign rec_accel_y = axis_q[4];
  assign rec_accel_z = axis_q[5];

endmodule

// File: rtl/imu_burst_frame_check_sva.sv
module imu_burst_frame_check_sva
  import imu_burst_pkg::*;
#(
  parameter int unsigned FRAME_WORDS = 20,
  parameter int unsigned CNT_W       = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             rec_valid,
  input logic             err_valid,
  input logic [1:0]       result_code,
  input logic [15:0]      rec_status,
  input logic [31:0]      rec_gyro_x,
  input logic [31:0]      rec_accel_z,
  input logic [15:0]      rec_counter,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             align_eval,
  input logic             align_found,
  input logic             crc_match_evt,
  input logic             crc_miss_evt
);

  a_r1_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(FRAME_WORDS));

  a_r3_sync_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && result_code == RES_SYNC_ERR) |-> $past(align_eval && !align_found));

  a_r6_crc_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && result_code == RES_CRC_ERR) |-> $past(crc_miss_evt));

  a_r6_err_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (result_code != RES_OK));

  a_r7_ok_source: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (result_code == RES_OK) && $past(crc_match_evt));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid && err_valid));

  a_r9_rec_single: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);

  a_r9_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);

  a_r10_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!rec_valid && !err_valid));

  a_r11_record_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_valid |-> ($stable(rec_status) && $stable(rec_gyro_x) &&
                    $stable(rec_accel_z) && $stable(rec_counter)));

endmodule

bind imu_burst_frame_check imu_burst_frame_check_sva #(
  .FRAME_WORDS (FRAME_WORDS),
  .CNT_W       (CNT_W)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .rec_valid     (rec_valid),
  .err_valid     (err_valid),
  .result_code   (result_code),
  .rec_status    (rec_status),
  .rec_gyro_x    (rec_gyro_x),
  .rec_accel_z   (rec_accel_z),
  .rec_counter   (rec_counter),
  .fill_cnt      (fill_cnt),
  .align_eval    (align_eval),
  .align_found   (align_found),
  .crc_match_evt (crc_match_evt),
  .crc_miss_evt  (crc_miss_evt)
);

// File: tb/imu_burst_frame_check_tb_top.sv
module imu_burst_frame_check_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SYNC = 16'hA5A5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start;
  logic        word_valid;
  logic [15:0] word_data;
  logic        rec_valid, err_valid;
  logic [1:0]  result_code;
  logic [15:0] rec_status, rec_temp, rec_counter;
  logic [31:0] rec_gyro_x, rec_gyro_y, rec_gyro_z;
  logic [31:0] rec_accel_x, rec_accel_y, rec_accel_z;

  always #(CLK_PERIOD / 2) clk = ~clk;

  imu_burst_frame_check dut_i (
    .clk (clk), .rst_n (rst_n), .frame_start (frame_start),
    .word_valid (word_valid), .word_data (word_data),
    .rec_valid (rec_valid), .err_valid (err_valid), .result_code (result_code),
    .rec_status (rec_status), .rec_temp (rec_temp),
    .rec_gyro_x (rec_gyro_x), .rec_gyro_y (rec_gyro_y), .rec_gyro_z (rec_gyro_z),
    .rec_accel_x (rec_accel_x), .rec_accel_y (rec_accel_y), .rec_accel_z (rec_accel_z),
    .rec_counter (rec_counter)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  logic [15:0] fw [20];
  int          m_res, m_p;
  logic [15:0] m_stat, m_temp, m_cnt;
  logic [31:0] m_ax [6];
  logic [15:0] h_stat = '0, h_temp = '0, h_cnt = '0;
  logic [31:0] h_ax [6] = '{default: '0};

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fwat(input int i);
    return (i < 20) ? fw[i] : 16'h0000;
  endfunction

  // Bit-serial form: a word's bits 0..15 in order equal low byte then high byte, LSB first.
  function automatic logic [31:0] bench_crc(input int p);
    logic [31:0] c;
    logic [15:0] w;
    logic        fb;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < 15; k++) begin
      w = fwat(p + k);
      for (int b = 0; b < 16; b++) begin
        fb = c[0] ^ w[b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic build_frame(input int lead, input int nsync, input int seed);
    logic [15:0] pl [15];
    logic [31:0] c;
    int p;
    for (int i = 0; i < 20; i++) fw[i] = 16'h0BAD;
    for (int i = 0; i < lead; i++) fw[i] = 16'h3C00 + 16'(i);
    for (int i = 0; i < nsync; i++) if (lead + i < 20) fw[lead + i] = SYNC;
    p = lead + nsync;
    pl[0]  = 16'h8000 | 16'(seed);
    pl[1]  = 16'h0100 + 16'(seed * 7);
    for (int k = 2; k < 14; k++) pl[k] = 16'(seed * 16'h1357 + k * 16'h0F1D);
    pl[14] = 16'h0042 + 16'(seed);
    for (int k = 0; k < 15; k++) if (p + k < 20) fw[p + k] = pl[k];
    c = bench_crc(p);
    if (p + 15 < 20) fw[p + 15] = c[15:0];
    if (p + 16 < 20) fw[p + 16] = c[31:16];
  endtask

  task automatic model_eval();
    logic [31:0] c, rx;
    m_p = -1;
    for (int i = 0; i < 4; i++)
      if (m_p < 0 && fw[i] == SYNC && fw[i + 1] != SYNC) m_p = i + 1;
    if (m_p < 0) begin
      m_res = 1;
    end else begin
      c  = bench_crc(m_p);
      rx = {fwat(m_p + 16), fwat(m_p + 15)};
      m_res  = (c == rx) ? 0 : 2;
      m_stat = fwat(m_p);
      m_temp = fwat(m_p + 1);
      for (int a = 0; a < 6; a++) m_ax[a] = {fwat(m_p + 2 * a + 3), fwat(m_p + 2 * a + 2)};
      m_cnt  = fwat(m_p + 14);
    end
  endtask

  task automatic send_words(input bit use_start, input bit gaps, input int n, input bit flood);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 4 == 2)) begin
        @(negedge clk);
        word_valid = 1'b0; frame_start = 1'b0;
      end
      @(negedge clk);
      word_valid  = 1'b1;
      word_data   = fw[i];
      frame_start = use_start && (i == 0);
    end
    @(negedge clk);
    frame_start = 1'b0;
    word_valid  = flood;
    word_data   = SYNC;
  endtask

  task automatic check_record(input string req);
    chk(req, "status", {48'd0, rec_status}, {48'd0, h_stat});
    chk(req, "temp", {48'd0, rec_temp}, {48'd0, h_temp});
    chk(req, "gyro_x", {32'd0, rec_gyro_x}, {32'd0, h_ax[0]});
    chk(req, "gyro_y", {32'd0, rec_gyro_y}, {32'd0, h_ax[1]});
    chk(req, "gyro_z", {32'd0, rec_gyro_z}, {32'd0, h_ax[2]});
    chk(req, "accel_x", {32'd0, rec_accel_x}, {32'd0, h_ax[3]});
    chk(req, "accel_y", {32'd0, rec_accel_y}, {32'd0, h_ax[4]});
    chk(req, "accel_z", {32'd0, rec_accel_z}, {32'd0, h_ax[5]});
    chk(req, "counter", {48'd0, rec_counter}, {48'd0, h_cnt});
  endtask

  // Drives fw as one frame and checks verdict, timing, strobes and record.
  task automatic run_frame(input string tag, input bit use_start, input bit gaps, input bit flood);
    int   k_hit, extra;
    logic g_rec, g_err;
    logic [1:0] g_code;
    model_eval();
    send_words(use_start, gaps, 20, flood);
    k_hit = 0; g_rec = 0; g_err = 0; g_code = 2'd3;
    for (int k = 1; k <= 40 && k_hit == 0; k++) begin
      @(posedge clk); #1;
      if (rec_valid || err_valid) begin
        k_hit = k; g_rec = rec_valid; g_err = err_valid; g_code = result_code;
      end
    end
    if (m_res == 1) chk({tag, " R3"}, "sync error cycle", 64'(k_hit), 64'd1);
    else            chk({tag, " R7"}, "verdict cycle", 64'(k_hit), 64'd32);
    chk({tag, " R3 R6 R7"}, "result_code", {62'd0, g_code}, 64'(m_res));
    chk({tag, " R9"}, "strobe pair", {62'd0, g_rec, g_err}, (m_res == 0) ? 64'd2 : 64'd1);
    extra = 0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      if (rec_valid || err_valid) extra++;
    end
    chk({tag, " R1 R9"}, "strobes after verdict", 64'(extra), 64'd0);
    if (m_res == 0) begin
      h_stat = m_stat; h_temp = m_temp; h_cnt = m_cnt;
      for (int a = 0; a < 6; a++) h_ax[a] = m_ax[a];
      check_record({tag, " R8"});
    end else begin
      check_record({tag, " R6 R11"});
    end
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R12", "rec_valid in reset", {63'd0, rec_valid}, 64'd0);
    chk("R12", "err_valid in reset", {63'd0, err_valid}, 64'd0);
    chk("R12", "result_code in reset", {62'd0, result_code}, 64'd0);
    check_record("R12");
  endtask

  task automatic t_first_frame_no_start();
    build_frame(1, 1, 3);
    run_frame("R12 R2 R4", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_two_sync();
    build_frame(1, 2, 11);
    run_frame("R2 two-sync", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sync_at_head();
    build_frame(0, 1, 21);
    run_frame("R2 head", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_no_sync();
    build_frame(2, 0, 5);
    run_frame("R3 none", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_sync_run_too_long();
    build_frame(0, 5, 6);
    run_frame("R3 long-run", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_payload_corrupt();
    build_frame(1, 1, 9);
    fw[2 + 6] = fw[2 + 6] ^ 16'h0001;
    run_frame("R4 R6 payload", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_crc_word_corrupt();
    build_frame(1, 2, 13);
    fw[3 + 16] = fw[3 + 16] ^ 16'h8000;
    run_frame("R5 R6 crc-hi", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_gapped_valid();
    build_frame(2, 1, 17);
    run_frame("R1 gaps", 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_flood_ignored();
    build_frame(1, 1, 29);
    run_frame("R1 flood", 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_late_payload();
    build_frame(3, 1, 31);
    run_frame("R5 tail-zero", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_restart_mid_capture();
    build_frame(1, 1, 40);
    send_words(1'b1, 1'b0, 10, 1'b0);
    build_frame(1, 2, 41);
    run_frame("R10 restart", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_abort_processing();
    int seen;
    build_frame(1, 1, 50);
    send_words(1'b1, 1'b0, 20, 1'b0);
    repeat (10) @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      if (rec_valid || err_valid) seen++;
    end
    chk("R10", "strobes of aborted frame", 64'(seen), 64'd0);
    check_record("R10 R11");
    build_frame(0, 2, 51);
    run_frame("R10 after-abort", 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; word_valid = 1'b0; word_data = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_first_frame_no_start();
    t_two_sync();
    t_sync_at_head();
    t_no_sync();
    t_sync_run_too_long();
    t_payload_corrupt();
    t_crc_word_corrupt();
    t_gapped_valid();
    t_flood_ignored();
    t_late_payload();
    t_restart_mid_capture();
    t_abort_processing();
    repeat (4) @(negedge clk);
    report();
  end

endmodule